// File: doc/BRIEF.md
# Sequential Binary to BCD Converter

This block turns an unsigned binary operand into packed decimal digits, for use by a slow consumer such as a bank of seven-segment digit drivers. A single-cycle start strobe captures the operand. The block then spends one clock cycle on each operand bit, starting with the most significant bit.

On every step the operand is shifted left. The bit that leaves the operand becomes the carry into a decimal doubling of a digit accumulator. Each 4-bit digit of the accumulator is doubled and the incoming carry is added. A digit whose raw result goes above nine is corrected by adding six, and the resulting carry moves into the next digit up. When the last bit has been consumed, the accumulator is copied to the result register and a one-cycle done pulse is raised. The result register keeps that value until the next conversion finishes.

Top module: `bin2bcd_seq`

## Requirements
- R1: After reset, `bcdOut` is zero and `doneStb` is low.
- R2: For every operand value from 0 to 255, the result is packed as follows: hundreds in `bcdOut[11:8]`, tens in `bcdOut[7:4]` and ones in `bcdOut[3:0]`. Each digit is in plain 0–9 binary coding.
- R3: `doneStb` is high for exactly one cycle per accepted start. If the start is sampled at clock edge k, `doneStb` and the new result appear after edge k+9.
- R4: A conversion runs exactly IN_W = 8 doubling steps, most significant operand bit first. The step counter never goes past 8.
- R5: Every digit of the accumulator holds a value from 0 to 9 at every cycle. The decimal correction adds six to a digit whose doubled sum plus carry exceeds nine, and that digit then carries into the next one.
- R6: A new conversion clears the accumulator before its first step. A start issued in the cycle right after a done pulse therefore gives a correct result, with nothing left over from the previous operand.
- R7: A start strobe that arrives while a conversion is in progress is ignored. It does not change the result, does not change the done timing, and produces no extra done pulse.
- R8: Between two completions, `bcdOut` holds the last completed result, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | One-cycle request to convert `binIn` |
| binIn | input | 8 | Unsigned binary operand, sampled with `startStb` |
| bcdOut | output | 12 | Packed three-digit decimal result |
| doneStb | output | 1 | One-cycle pulse when `bcdOut` is updated |

## Verification
All 256 operand values are converted back to back. This covers each corner of the digit correction:
- values that never exceed nine in any digit;
- values that raise a tens carry (10, 99);
- values that raise a hundreds carry (100, 199);
- the maximum value, 255.

Because each sweep conversion starts the cycle after the previous done pulse, a failure to clear the accumulator shows up as a wrong digit. A large operand is started and then interrupted by a second start with a small operand. The result must stay that of the large operand, with exactly one done pulse at the original time. Idle cycles with a changing `binIn` after each completion separate a held result from one that drifts.

// File: rtl/bin2bcd_pkg.sv
package bin2bcd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } convState_t;

  typedef struct packed {
    logic clearAcc;
    logic loadOp;
    logic stepEn;
    logic capture;
  } convStrobes_t;

endpackage

// File: rtl/bcd_digit_step.sv
module bcd_digit_step (
  input  logic [3:0] digIn,
  input  logic       carryIn,
  output logic [3:0] digOut,
  output logic       carryOut
);
  logic [4:0] rawSum;
  logic [4:0] fixedSum;

  always_comb begin
    rawSum   = {digIn, carryIn};
    fixedSum = rawSum + 5'd6;
    if (rawSum > 5'd9) begin
      digOut   = fixedSum[3:0];
      carryOut = 1'b1;
    end else begin
      digOut   = rawSum[3:0];
      carryOut = 1'b0;
    end
  end
endmodule

// File: rtl/bin2bcd_datapath.sv
module bin2bcd_datapath
  import bin2bcd_pkg::*;
#(
  parameter int IN_W   = 8,
  parameter int DIGITS = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  convStrobes_t          strobes,
  input  logic [IN_W-1:0]       binIn,
  output logic [DIGITS*4-1:0]   resultOut
);
  localparam int ACC_W = DIGITS * 4;

  logic [IN_W-1:0]  opReg;
  logic [ACC_W-1:0] accReg;
  logic [ACC_W-1:0] accNext;
  logic [ACC_W-1:0] resultReg;
  logic [DIGITS:0]  carryChain;

  assign carryChain[0] = opReg[IN_W-1];

  for (genvar d = 0; d < DIGITS; d++) begin : gDigit
    bcd_digit_step uStep (
      .digIn    (accReg[d*4 +: 4]),
      .carryIn  (carryChain[d]),
      .digOut   (accNext[d*4 +: 4]),
      .carryOut (carryChain[d+1])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg     <= '0;
      accReg    <= '0;
      resultReg <= '0;
    end else begin
      if (strobes.loadOp)
        opReg <= binIn;
      else if (strobes.stepEn)
        opReg <= {opReg[IN_W-2:0], 1'b0};

      if (strobes.clearAcc)
        accReg <= '0;
      else if (strobes.stepEn)
        accReg <= accNext;

      if (strobes.capture)
        resultReg <= accReg;
    end
  end

  assign resultOut = resultReg;

  for (genvar d = 0; d < DIGITS; d++) begin : gDigitCheck
    assert_acc_digits_bcd_R5: assert property (@(posedge clk) disable iff (!rstN)
      accReg[d*4 +: 4] <= 4'd9);
  end

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAcc |=> (accReg == '0));

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(resultReg));

endmodule

// File: rtl/bin2bcd_ctrl.sv
module bin2bcd_ctrl
  import bin2bcd_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startStb,
  output convStrobes_t strobes,
  output logic         doneStb
);
  localparam int CNT_W = $clog2(IN_W + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(IN_W - 1);

  convState_t      state;
  logic [CNT_W-1:0] stepCount;

  always_comb begin
    strobes          = '0;
    strobes.clearAcc = (state == ST_IDLE) && startStb;
    strobes.loadOp   = (state == ST_IDLE) && startStb;
    strobes.stepEn   = (state == ST_RUN);
    strobes.capture  = (state == ST_DONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      stepCount <= '0;
      doneStb   <= 1'b0;
    end else begin
      doneStb <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          stepCount <= '0;
          if (startStb) state <= ST_RUN;
        end
        ST_RUN: begin
          stepCount <= stepCount + 1'b1;
          if (stepCount == LAST_STEP) state <= ST_DONE;
        end
        ST_DONE: begin
          doneStb <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !doneStb);

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |=> (stepCount <= CNT_W'(IN_W)));

  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && startStb && stepCount != LAST_STEP) |=> (state == ST_RUN));

endmodule

// File: rtl/bin2bcd_seq.sv
module bin2bcd_seq
  import bin2bcd_pkg::*;
#(
  parameter int IN_W   = 8,
  parameter int DIGITS = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startStb,
  input  logic [IN_W-1:0]     binIn,
  output logic [DIGITS*4-1:0] bcdOut,
  output logic                doneStb
);
  convStrobes_t strobes;

  bin2bcd_ctrl #(.IN_W(IN_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startStb (startStb),
    .strobes  (strobes),
    .doneStb  (doneStb)
  );

  bin2bcd_datapath #(.IN_W(IN_W), .DIGITS(DIGITS)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .binIn     (binIn),
    .resultOut (bcdOut)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(!rstN) |-> (bcdOut == '0 && !doneStb));

endmodule

// File: tb/bin2bcd_seq_test.sv
module bin2bcd_seq_test;

  typedef struct {
    int value;
    int dueCycle;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startStb = 1'b0;
  logic [7:0]  binIn = '0;
  logic [11:0] bcdOut;
  logic        doneStb;

  int total = 0;
  int bad = 0;
  int cycleCnt = 0;
  expItem_t expQ[$];
  logic [11:0] lastExp = '0;

  bin2bcd_seq uut (
    .clk      (clk),
    .rstN     (rstN),
    .startStb (startStb),
    .binIn    (binIn),
    .bcdOut   (bcdOut),
    .doneStb  (doneStb)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  function automatic logic [11:0] toBcd(int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // driver: launch a conversion and record what should come back and when
  task automatic launch(int v);
    expItem_t it;
    @(negedge clk);
    startStb = 1'b1;
    binIn    = 8'(v);
    it.value    = v;
    it.dueCycle = cycleCnt + 10;
    expQ.push_back(it);
    @(negedge clk);
    startStb = 1'b0;
    binIn    = 8'(~v);
    repeat (8) @(negedge clk);
  endtask

  // monitor / scoreboard (R2, R3)
  always @(negedge clk) begin
    if (rstN && doneStb) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R3/R7 unexpected done", 1, 0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        lastExp = toBcd(it.value);
        check(bcdOut == lastExp, "R2 value", int'(bcdOut), int'(lastExp));
        check(cycleCnt == it.dueCycle, "R3 timing", cycleCnt, it.dueCycle);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(bcdOut == 12'h000, "R1 bcdOut", int'(bcdOut), 0);
    check(doneStb == 1'b0, "R1 doneStb", int'(doneStb), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2, R5, R6, R4: full back-to-back sweep, corner values included
    for (int v = 0; v < 256; v++) launch(v);
    launch(255);
    launch(0);
    @(negedge clk);
    @(negedge clk);
    check(expQ.size() == 0, "R3 all done seen", expQ.size(), 0);

    // R8: result holds while binIn moves and no start arrives
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      binIn = 8'(k * 37);
      check(bcdOut == toBcd(0), "R8 hold", int'(bcdOut), int'(toBcd(0)));
    end

    // R7: start while busy is ignored
    begin
      expItem_t it;
      @(negedge clk);
      startStb = 1'b1;
      binIn    = 8'd200;
      it.value    = 200;
      it.dueCycle = cycleCnt + 10;
      expQ.push_back(it);
      @(negedge clk);
      startStb = 1'b0;
      repeat (2) @(negedge clk);
      startStb = 1'b1;
      binIn    = 8'd5;
      @(negedge clk);
      startStb = 1'b0;
      repeat (20) @(negedge clk);
      check(expQ.size() == 0, "R7 single done", expQ.size(), 0);
      check(bcdOut == 12'h200, "R7 result kept", int'(bcdOut), 12'h200);
    end

    // R8: another idle stretch after the interrupted run
    repeat (5) @(negedge clk);
    check(bcdOut == 12'h200, "R8 hold after R7", int'(bcdOut), 12'h200);

    // R6: small value right after large one
    launch(199);
    launch(7);
    repeat (3) @(negedge clk);
    check(bcdOut == 12'h007, "R6 clear", int'(bcdOut), 12'h007);

    finishRun();
  end

endmodule